// File: doc/BRIEF.md
# Dual PCM port startup controller

This block starts up two voice PCM serial ports, A and B. Both ports share one internally generated port clock. The block picks which input pin feeds the port clock generator. It then steps through a fixed sequence: powered down, waiting for the first frame sync on the reference port, waiting for the clock generator to lock, and running.

In every phase the block forces defined levels on the frame-sync, bit-clock and serial-data outputs. Once lock is reached, it generates the bit clock and frame sync for whichever port is the master.

The clock generator itself is modelled as a digital lock timer. The timer counts a one-per-millisecond strobe on the system clock. Master clocks are derived from a strobe at 64 times the frame rate.

Each port is configured with these inputs:
- a master flag;
- a word-clock (I2S-style) framing flag;
- a companding law, coded as 0 for 16-bit linear, 1 for A-law, and 2 or 3 for mu-law.

A 4-bit mode code picks the reference pin and its rate.

Top module: `pcm_dual_start`

## Requirements
- R1: `ref_clk_o` follows the reference pin that the mode selects. Mode 0 selects `sync_a_i`. Modes 1, 2, 3 and 11 select `bick_a_i`. Mode 4 selects `sync_b_i`. Modes 5, 6, 7 and 15 select `bick_b_i`. For an unsupported mode it is 0.
- R2: `err_o` is 1 for every mode code other than 0 to 7, 11 and 15.
- R3: `err_o` is 1 when `master_a_i` equals `master_b_i`.
- R4: `err_o` is 1 for mode 1 with `i2s_a_i`=1, and for mode 5 with `i2s_b_i`=1.
- R5: While `enable_i` is 0 or `err_o` is 1, the following hold:
  - all four clock output enables are 0;
  - both serial data outputs are 0;
  - `lock_done_o` is 0 from the next clock.
- R6: After enable, until a rising edge arrives on the reference port's frame sync input, the following hold:
  - each serial data output is 0 for linear law and 1 for A-law or mu-law;
  - the master port drives its bit clock 0 and its frame sync equal to its I2S flag.
- R7: The lock wait starts at the first frame-sync rising edge on the reference port. `lock_done_o` rises after the 260th millisecond strobe for modes 0 and 4. For all other valid modes it rises after the 40th strobe.
- R8: During the lock wait and while running, each port's serial data output carries a silence word, most significant bit first:
  - 16 zero bits for linear law;
  - 0xD5 for A-law;
  - 0xFF for mu-law.
  The bit index resets at a frame-sync rising edge and advances on each bit-clock falling edge. All bits past the word are 0. A slave port counts edges of its input pins.
- R9: During the lock wait, the master port drives its bit clock 0. It drives its frame sync 0, or 1 when its I2S flag is set.
- R10: While running, the master bit clock comes from a counter of 64fs strobes. The counter is cleared while powered down. With `bck_sel_i`=0 the bit clock is bit 1 of the counter (16fs). With `bck_sel_i`=1 it is bit 0 of the counter (32fs).
- R11: While running, the master frame sync is high during bit 0 of the frame. That is counter values 0 to 3 at 16fs, and 0 to 1 at 32fs. With the I2S flag set, the frame sync is instead counter bit 5, a 50% word clock.
- R12: A change of mode code while enabled restarts the sequence in the wait-for-frame-sync phase. It drops `lock_done_o` and restarts the lock timer from zero.
- R13: A slave port never enables its frame-sync or bit-clock outputs. At most one port drives a frame sync at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ms_tick_i | input | 1 | One-cycle strobe per millisecond |
| fs64_tick_i | input | 1 | One-cycle strobe at 64 times the frame rate |
| enable_i | input | 1 | Power-up request for the port clock |
| mode_i | input | 4 | Reference pin and rate code |
| master_a_i | input | 1 | Port A is clock master |
| master_b_i | input | 1 | Port B is clock master |
| i2s_a_i | input | 1 | Port A word-clock framing |
| i2s_b_i | input | 1 | Port B word-clock framing |
| law_a_i | input | 2 | Port A law: 0 linear, 1 A-law, 2/3 mu-law |
| law_b_i | input | 2 | Port B law |
| bck_sel_i | input | 1 | Master bit clock rate: 0 = 16fs, 1 = 32fs |
| sync_a_i | input | 1 | Port A frame sync pin input |
| bick_a_i | input | 1 | Port A bit clock pin input |
| sync_b_i | input | 1 | Port B frame sync pin input |
| bick_b_i | input | 1 | Port B bit clock pin input |
| sync_a_o | output | 1 | Port A frame sync drive value |
| sync_a_oe_o | output | 1 | Port A frame sync drive enable |
| bick_a_o | output | 1 | Port A bit clock drive value |
| bick_a_oe_o | output | 1 | Port A bit clock drive enable |
| sync_b_o | output | 1 | Port B frame sync drive value |
| sync_b_oe_o | output | 1 | Port B frame sync drive enable |
| bick_b_o | output | 1 | Port B bit clock drive value |
| bick_b_oe_o | output | 1 | Port B bit clock drive enable |
| sdto_a_o | output | 1 | Port A serial data output |
| sdto_b_o | output | 1 | Port B serial data output |
| ref_clk_o | output | 1 | Selected reference pin level |
| err_o | output | 1 | Illegal configuration flag |
| lock_done_o | output | 1 | Lock wait complete |

## Verification
Some properties are checked on every cycle:
- the sequencer falls to powered-down one clock after enable drops or an error appears;
- a mode change sends it back to the wait phase;
- lock completion only happens on a millisecond strobe taken in the lock phase;
- the 32fs master bit clock toggles on every 64fs strobe;
- a master port holds its clocks low during the lock wait;
- the two ports never both drive a frame sync.

Other behaviour only the bench scenarios can show:
- the exact lock length for each reference rate;
- the bit-by-bit silence words clocked by slave pins;
- the full master clock and frame waveforms in both framings;
- the error decode over all mode, master and framing combinations.

// File: rtl/pcm_start_pkg.sv
package pcm_start_pkg;

  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_WAIT = 2'd1,
    PH_LOCK = 2'd2,
    PH_RUN  = 2'd3
  } phase_t;

  localparam int WORD_W = 16;

  // Silence word, left aligned in 16 bits so 8-bit laws pad with zeros.
  function automatic logic [WORD_W-1:0] silence_word(input logic [1:0] law);
    logic [WORD_W-1:0] w;
    case (law)
      2'd0:    w = 16'h0000;
      2'd1:    w = 16'hD500;
      default: w = 16'hFF00;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/pcm_cfg_check.sv
module pcm_cfg_check (
  input  logic [3:0] mode_i,
  input  logic       master_a_i,
  input  logic       master_b_i,
  input  logic       i2s_a_i,
  input  logic       i2s_b_i,
  input  logic       sync_a_i,
  input  logic       bick_a_i,
  input  logic       sync_b_i,
  input  logic       bick_b_i,
  output logic       err_o,
  output logic       ref_port_o,
  output logic       ref_fs_o,
  output logic       ref_clk_o
);

  logic supported;
  logic role_bad;
  logic frame_bad;
  logic pin_lvl;

  always_comb begin
    supported  = ~mode_i[3] || (mode_i == 4'd11) || (mode_i == 4'd15);
    ref_port_o = mode_i[2];
    ref_fs_o   = ~mode_i[3] && (mode_i[1:0] == 2'd0);
    role_bad   = (master_a_i == master_b_i);
    frame_bad  = ((mode_i == 4'd1) && i2s_a_i) || ((mode_i == 4'd5) && i2s_b_i);
    err_o      = ~supported || role_bad || frame_bad;
  end

  always_comb begin
    if (ref_port_o) pin_lvl = ref_fs_o ? sync_b_i : bick_b_i;
    else            pin_lvl = ref_fs_o ? sync_a_i : bick_a_i;
    ref_clk_o = supported ? pin_lvl : 1'b0;
  end

endmodule

// File: rtl/pcm_seq.sv
module pcm_seq
  import pcm_start_pkg::*;
#(
  parameter int LONG_MS  = 260,
  parameter int SHORT_MS = 40
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       err_i,
  input  logic [3:0] mode_i,
  input  logic       ref_fs_i,
  input  logic       ref_port_i,
  input  logic       rise_a_i,
  input  logic       rise_b_i,
  input  logic       ms_tick_i,
  output phase_t     phase_o,
  output logic       lock_done_o
);

  localparam int CNT_W = $clog2(LONG_MS + 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_MS - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_MS - 1);

  phase_t           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [3:0]       mode_q;
  logic             mode_chg;
  logic             ref_rise;
  logic [CNT_W-1:0] last;

  assign mode_chg = (mode_i != mode_q);
  assign ref_rise = ref_port_i ? rise_b_i : rise_a_i;
  assign last     = ref_fs_i ? LONG_LAST : SHORT_LAST;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (!enable_i || err_i) begin
      phase_d = PH_OFF;
      cnt_d   = '0;
    end else if (mode_chg) begin
      phase_d = PH_WAIT;
      cnt_d   = '0;
    end else begin
      case (phase_q)
        PH_OFF:  phase_d = PH_WAIT;
        PH_WAIT: if (ref_rise) begin
                   phase_d = PH_LOCK;
                   cnt_d   = '0;
                 end
        PH_LOCK: if (ms_tick_i) begin
                   if (cnt_q == last) phase_d = PH_RUN;
                   else               cnt_d   = cnt_q + 1'b1;
                 end
        default: phase_d = PH_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_OFF;
      cnt_q   <= '0;
      mode_q  <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      mode_q  <= mode_i;
    end
  end

  assign phase_o     = phase_q;
  assign lock_done_o = (phase_q == PH_RUN);

  // R5
  off_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i || err_i) |=> (phase_q == PH_OFF));

  // R12
  mode_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !err_i && mode_chg) |=> (phase_q == PH_WAIT));

  // R7
  lock_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_q == PH_RUN) |-> ($past(phase_q) == PH_LOCK && $past(ms_tick_i)));

endmodule

// File: rtl/pcm_master_gen.sv
module pcm_master_gen #(
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             tick_i,
  input  logic             fast_i,
  output logic             bick_o,
  output logic             pulse_o,
  output logic             wck_o,
  output logic [IDX_W-1:0] idx_o
);

  localparam int FRAME_TICKS = 64;
  localparam int CNT_W = $clog2(FRAME_TICKS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = !active_i || tick_i;
  assign cnt_d  = active_i ? cnt_q + 1'b1 : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb begin
    bick_o  = fast_i ? cnt_q[0] : cnt_q[1];
    idx_o   = fast_i ? IDX_W'(cnt_q[CNT_W-1:1]) : IDX_W'(cnt_q[CNT_W-1:2]);
    pulse_o = (idx_o == '0);
    wck_o   = cnt_q[CNT_W-1];
  end

  // R10
  fast_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && tick_i) |=> (cnt_q[0] != $past(cnt_q[0])));

endmodule

// File: rtl/pcm_port_out.sv
module pcm_port_out
  import pcm_start_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             off_i,
  input  phase_t           phase_i,
  input  logic             master_i,
  input  logic             i2s_i,
  input  logic [1:0]       law_i,
  input  logic             sync_i,
  input  logic             bick_i,
  input  logic             gen_bick_i,
  input  logic             gen_pulse_i,
  input  logic             gen_wck_i,
  input  logic [IDX_W-1:0] gen_idx_i,
  output logic             sync_o,
  output logic             sync_oe_o,
  output logic             bick_o,
  output logic             bick_oe_o,
  output logic             sdto_o,
  output logic             rise_o
);

  logic [STAGES:0]  sy_q, bk_q;
  logic             bk_fall;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic [IDX_W-1:0] sel_idx;
  logic [IDX_W-1:0] rev_idx;
  logic [WORD_W-1:0] word;
  logic             data_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sy_q <= '0;
      bk_q <= '0;
    end else begin
      sy_q <= {sy_q[STAGES-1:0], sync_i};
      bk_q <= {bk_q[STAGES-1:0], bick_i};
    end
  end

  assign rise_o  = sy_q[STAGES-1] & ~sy_q[STAGES];
  assign bk_fall = ~bk_q[STAGES-1] & bk_q[STAGES];

  always_comb begin
    idx_en = 1'b0;
    idx_d  = idx_q;
    if (off_i || rise_o) begin
      idx_en = 1'b1;
      idx_d  = '0;
    end else if (bk_fall && (idx_q != '1)) begin
      idx_en = 1'b1;
      idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  always_comb begin
    sel_idx  = master_i ? gen_idx_i : idx_q;
    rev_idx  = IDX_W'(WORD_W - 1) - sel_idx;
    word     = silence_word(law_i);
    data_bit = (sel_idx < IDX_W'(WORD_W)) ? word[rev_idx[$clog2(WORD_W)-1:0]] : 1'b0;
  end

  always_comb begin
    sync_o    = 1'b0;
    sync_oe_o = 1'b0;
    bick_o    = 1'b0;
    bick_oe_o = 1'b0;
    sdto_o    = 1'b0;
    if (!off_i) begin
      if (phase_i == PH_WAIT) sdto_o = (law_i != 2'd0);
      else                    sdto_o = data_bit;
      if (master_i) begin
        sync_oe_o = 1'b1;
        bick_oe_o = 1'b1;
        if (phase_i == PH_RUN) begin
          bick_o = gen_bick_i;
          sync_o = i2s_i ? gen_wck_i : gen_pulse_i;
        end else begin
          bick_o = 1'b0;
          sync_o = i2s_i;
        end
      end
    end
  end

  // R9
  lock_clock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!off_i && master_i && phase_i == PH_LOCK) |-> (bick_oe_o && !bick_o && sync_o == i2s_i));

endmodule

// File: rtl/pcm_dual_start.sv
module pcm_dual_start
  import pcm_start_pkg::*;
#(
  parameter int LONG_MS  = 260,
  parameter int SHORT_MS = 40,
  parameter int IDX_W    = 5,
  parameter int STAGES   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ms_tick_i,
  input  logic       fs64_tick_i,
  input  logic       enable_i,
  input  logic [3:0] mode_i,
  input  logic       master_a_i,
  input  logic       master_b_i,
  input  logic       i2s_a_i,
  input  logic       i2s_b_i,
  input  logic [1:0] law_a_i,
  input  logic [1:0] law_b_i,
  input  logic       bck_sel_i,
  input  logic       sync_a_i,
  input  logic       bick_a_i,
  input  logic       sync_b_i,
  input  logic       bick_b_i,
  output logic       sync_a_o,
  output logic       sync_a_oe_o,
  output logic       bick_a_o,
  output logic       bick_a_oe_o,
  output logic       sync_b_o,
  output logic       sync_b_oe_o,
  output logic       bick_b_o,
  output logic       bick_b_oe_o,
  output logic       sdto_a_o,
  output logic       sdto_b_o,
  output logic       ref_clk_o,
  output logic       err_o,
  output logic       lock_done_o
);

  localparam int NPORT = 2;

  logic             ref_port, ref_fs;
  phase_t           phase;
  logic             off;
  logic             g_bick, g_pulse, g_wck;
  logic [IDX_W-1:0] g_idx;

  logic [NPORT-1:0] p_sync_in, p_bick_in, p_mst, p_i2s;
  logic [1:0]       p_law [NPORT];
  logic [NPORT-1:0] p_sync, p_sync_oe, p_bick, p_bick_oe, p_sdto, p_rise;

  assign p_sync_in = {sync_b_i, sync_a_i};
  assign p_bick_in = {bick_b_i, bick_a_i};
  assign p_mst     = {master_b_i, master_a_i};
  assign p_i2s     = {i2s_b_i, i2s_a_i};
  assign p_law[0]  = law_a_i;
  assign p_law[1]  = law_b_i;

  pcm_cfg_check u_cfg (
    .mode_i     (mode_i),
    .master_a_i (master_a_i),
    .master_b_i (master_b_i),
    .i2s_a_i    (i2s_a_i),
    .i2s_b_i    (i2s_b_i),
    .sync_a_i   (sync_a_i),
    .bick_a_i   (bick_a_i),
    .sync_b_i   (sync_b_i),
    .bick_b_i   (bick_b_i),
    .err_o      (err_o),
    .ref_port_o (ref_port),
    .ref_fs_o   (ref_fs),
    .ref_clk_o  (ref_clk_o)
  );

  pcm_seq #(.LONG_MS(LONG_MS), .SHORT_MS(SHORT_MS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .err_i       (err_o),
    .mode_i      (mode_i),
    .ref_fs_i    (ref_fs),
    .ref_port_i  (ref_port),
    .rise_a_i    (p_rise[0]),
    .rise_b_i    (p_rise[1]),
    .ms_tick_i   (ms_tick_i),
    .phase_o     (phase),
    .lock_done_o (lock_done_o)
  );

  assign off = (phase == PH_OFF) || err_o;

  pcm_master_gen #(.IDX_W(IDX_W)) u_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (!off),
    .tick_i   (fs64_tick_i),
    .fast_i   (bck_sel_i),
    .bick_o   (g_bick),
    .pulse_o  (g_pulse),
    .wck_o    (g_wck),
    .idx_o    (g_idx)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    pcm_port_out #(.IDX_W(IDX_W), .STAGES(STAGES)) u_port (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .off_i       (off),
      .phase_i     (phase),
      .master_i    (p_mst[p]),
      .i2s_i       (p_i2s[p]),
      .law_i       (p_law[p]),
      .sync_i      (p_sync_in[p]),
      .bick_i      (p_bick_in[p]),
      .gen_bick_i  (g_bick),
      .gen_pulse_i (g_pulse),
      .gen_wck_i   (g_wck),
      .gen_idx_i   (g_idx),
      .sync_o      (p_sync[p]),
      .sync_oe_o   (p_sync_oe[p]),
      .bick_o      (p_bick[p]),
      .bick_oe_o   (p_bick_oe[p]),
      .sdto_o      (p_sdto[p]),
      .rise_o      (p_rise[p])
    );
  end

  assign sync_a_o    = p_sync[0];
  assign sync_a_oe_o = p_sync_oe[0];
  assign bick_a_o    = p_bick[0];
  assign bick_a_oe_o = p_bick_oe[0];
  assign sync_b_o    = p_sync[1];
  assign sync_b_oe_o = p_sync_oe[1];
  assign bick_b_o    = p_bick[1];
  assign bick_b_oe_o = p_bick_oe[1];
  assign sdto_a_o    = p_sdto[0];
  assign sdto_b_o    = p_sdto[1];

  // R13
  one_driver_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sync_a_oe_o && sync_b_oe_o));

endmodule

// File: tb/tb_pcm_dual_start.sv
module tb_pcm_dual_start;

  logic clk = 1'b0;
  logic rst_n;
  logic ms_tick, fs64_tick, enable;
  logic [3:0] mode;
  logic master_a, master_b, i2s_a, i2s_b, bck_sel;
  logic [1:0] law_a, law_b;
  logic sync_a, bick_a, sync_b, bick_b;
  logic sync_a_o, sync_a_oe, bick_a_o, bick_a_oe;
  logic sync_b_o, sync_b_oe, bick_b_o, bick_b_oe;
  logic sdto_a, sdto_b, ref_clk, err, lock_done;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pcm_dual_start dut (
    .clk_i(clk), .rst_ni(rst_n), .ms_tick_i(ms_tick), .fs64_tick_i(fs64_tick),
    .enable_i(enable), .mode_i(mode), .master_a_i(master_a), .master_b_i(master_b),
    .i2s_a_i(i2s_a), .i2s_b_i(i2s_b), .law_a_i(law_a), .law_b_i(law_b),
    .bck_sel_i(bck_sel), .sync_a_i(sync_a), .bick_a_i(bick_a), .sync_b_i(sync_b),
    .bick_b_i(bick_b), .sync_a_o(sync_a_o), .sync_a_oe_o(sync_a_oe), .bick_a_o(bick_a_o),
    .bick_a_oe_o(bick_a_oe), .sync_b_o(sync_b_o), .sync_b_oe_o(sync_b_oe),
    .bick_b_o(bick_b_o), .bick_b_oe_o(bick_b_oe), .sdto_a_o(sdto_a), .sdto_b_o(sdto_b),
    .ref_clk_o(ref_clk), .err_o(err), .lock_done_o(lock_done)
  );

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ms(input int n);
    repeat (n) begin
      ms_tick = 1'b1; clks(1);
      ms_tick = 1'b0; clks(3);
    end
  endtask

  task automatic fs_tick();
    fs64_tick = 1'b1; clks(1);
    fs64_tick = 1'b0; clks(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  function automatic logic exp_bit(input int law, input int k);
    logic [15:0] w;
    int len;
    len = (law == 0) ? 16 : 8;
    w = (law == 0) ? 16'h0000 : (law == 1) ? 16'h00D5 : 16'h00FF;
    return (k < len) ? w[len-1-k] : 1'b0;
  endfunction

  function automatic logic [5:0] drive_word();
    return {sync_a_oe, bick_a_oe, sync_b_oe, bick_b_oe, sdto_a, sdto_b};
  endfunction

  task automatic set_pins(input logic [3:0] v);
    {bick_b, sync_b, bick_a, sync_a} = v;
  endtask

  task automatic raise_sync(input logic port_b);
    if (port_b) sync_b = 1'b1; else sync_a = 1'b1;
    clks(10);
    sync_a = 1'b0; sync_b = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ms_tick = 1'b0; fs64_tick = 1'b0; enable = 1'b0;
    mode = 4'd0; master_a = 1'b0; master_b = 1'b1; i2s_a = 1'b0; i2s_b = 1'b0;
    bck_sel = 1'b0; law_a = 2'd0; law_b = 2'd0; set_pins(4'b0000);
    clks(3);
    rst_n = 1'b1;
    clks(2);
    // R5 reset and disabled state
    chk("R5 reset drives", 32'(drive_word()), 32'h0);
    chk("R5 reset lock", 32'(lock_done), 32'h0);

    // R2 R3 R4 R5 exhaustive configuration sweep
    enable = 1'b1;
    for (int m = 0; m < 16; m++) begin
      for (int c = 0; c < 16; c++) begin
        logic unsup, role, frame, e;
        mode = 4'(m); master_a = c[0]; master_b = c[1]; i2s_a = c[2]; i2s_b = c[3];
        clks(3);
        unsup = !((m < 8) || (m == 11) || (m == 15));
        role  = (c[0] == c[1]);
        frame = ((m == 1) && c[2]) || ((m == 5) && c[3]);
        e = unsup || role || frame;
        if (unsup)     chk("R2 unsupported mode", 32'(err), 32'(e));
        else if (role) chk("R3 master pair", 32'(err), 32'(e));
        else           chk("R4 mode framing", 32'(err), 32'(e));
        if (e) chk("R5 error drives", 32'(drive_word()), 32'h0);
      end
    end
    master_a = 1'b0; master_b = 1'b1; i2s_a = 1'b0; i2s_b = 1'b0;

    // R1 reference pin selection
    for (int m = 0; m < 16; m++) begin
      int p;
      if (!((m < 8) || (m == 11) || (m == 15))) continue;
      mode = 4'(m);
      if (m == 11)      p = 1;
      else if (m == 15) p = 3;
      else              p = (m >= 4 ? 2 : 0) + ((m % 4) != 0 ? 1 : 0);
      set_pins(4'(1 << p)); #1;
      chk("R1 selected pin high", 32'(ref_clk), 32'h1);
      set_pins(~4'(1 << p)); #1;
      chk("R1 selected pin low", 32'(ref_clk), 32'h0);
    end
    mode = 4'd9; set_pins(4'b1111); #1;
    chk("R1 unsupported mode", 32'(ref_clk), 32'h0);
    set_pins(4'b0000);

    // R6 R8 R9 idle levels and silence words, port A slave, B master
    for (int l = 0; l < 3; l++) begin
      enable = 1'b0; mode = 4'd0;
      clks(3);
      chk("R5 disabled drives", 32'(drive_word()), 32'h0);
      law_a = 2'(l); i2s_b = (l == 1);
      enable = 1'b1;
      clks(4);
      chk("R6 wait data level", 32'(sdto_a), 32'(l != 0));
      chk("R6 wait master clocks", 32'({bick_b_oe, bick_b_o, sync_b_oe, sync_b_o}),
          32'({1'b1, 1'b0, 1'b1, i2s_b}));
      sync_a = 1'b1;
      clks(8);
      chk("R9 lock master clocks", 32'({bick_b_oe, bick_b_o, sync_b_oe, sync_b_o}),
          32'({1'b1, 1'b0, 1'b1, i2s_b}));
      chk("R8 silence bit 0", 32'(sdto_a), 32'(exp_bit(l, 0)));
      sync_a = 1'b0;
      for (int k = 1; k < 18; k++) begin
        bick_a = 1'b1; clks(4);
        bick_a = 1'b0; clks(8);
        chk($sformatf("R8 law %0d bit %0d", l, k), 32'(sdto_a), 32'(exp_bit(l, k)));
      end
      chk("R7 still locking", 32'(lock_done), 32'h0);
    end
    law_a = 2'd2; i2s_b = 1'b0;

    // R7 lock length per reference rate
    for (int t = 0; t < 5; t++) begin
      int m, n;
      logic pb;
      m = (t == 0) ? 3 : (t == 1) ? 4 : (t == 2) ? 11 : (t == 3) ? 15 : 0;
      pb = (m == 4) || (m == 15);
      n = (m == 0 || m == 4) ? 260 : 40;
      enable = 1'b0; clks(3);
      mode = 4'(m); master_a = pb; master_b = !pb;
      enable = 1'b1; clks(4);
      raise_sync(pb);
      ms(n - 1);
      chk($sformatf("R7 mode %0d before end", m), 32'(lock_done), 32'h0);
      ms(1);
      chk($sformatf("R7 mode %0d at end", m), 32'(lock_done), 32'h1);
    end

    // R10 R11 R13 master clock generation, B master, mode 0 running
    begin
      int n;
      n = 0;
      for (int cfg = 0; cfg < 4; cfg++) begin
        bck_sel = cfg[0]; i2s_b = cfg[1];
        for (int t = 0; t < 64; t++) begin
          logic [5:0] c;
          logic eb, es;
          fs_tick();
          n++;
          c = 6'(n % 64);
          eb = bck_sel ? c[0] : c[1];
          if (i2s_b) es = c[5];
          else       es = bck_sel ? (c < 2) : (c < 4);
          chk("R10 master bit clock", 32'({bick_b_oe, bick_b_o}), 32'({1'b1, eb}));
          chk("R11 master frame sync", 32'({sync_b_oe, sync_b_o}), 32'({1'b1, es}));
          chk("R13 slave not driving", 32'({sync_a_oe, bick_a_oe}), 32'h0);
        end
      end
      bck_sel = 1'b0; i2s_b = 1'b0;
    end

    // R12 restart of the timer on mode change
    enable = 1'b0; clks(3);
    mode = 4'd0; enable = 1'b1; clks(4);
    raise_sync(1'b0);
    ms(200);
    mode = 4'd3;
    clks(3);
    chk("R12 back to wait", 32'(lock_done), 32'h0);
    chk("R12 wait data level", 32'(sdto_a), 32'h1);
    raise_sync(1'b0);
    ms(39);
    chk("R12 restarted timer not done", 32'(lock_done), 32'h0);
    ms(1);
    chk("R12 restarted timer done", 32'(lock_done), 32'h1);
    mode = 4'd2;
    clks(3);
    chk("R12 run then mode change", 32'(lock_done), 32'h0);
    enable = 1'b0;
    clks(3);
    chk("R5 disable drops lock", 32'(lock_done), 32'h0);
    chk("R5 disable drives", 32'(drive_word()), 32'h0);

    finish_run();
  end

endmodule